// File: doc/BRIEF.md
# Burst Read Boundary Latency Sequencer

This block is the device-side sequencer of a synchronous burst-read memory. A host drives the active-low address strobe for one clock with a starting word address. The sequencer captures that address and waits out a fixed access latency. It then delivers one word per clock from a linear, incrementing address. The word store is a small combinational lookup, computed from the address.

The address space is split into aligned segments. When the burst steps from the last word of a segment into the next one, the sequencer holds back the next word for a fixed number of wait cycles. During those cycles it keeps the data output unchanged. There is one exception: a burst that starts on one of the two words just below a segment edge pays no penalty on its first crossing. A runtime configuration input chooses how the ready output is timed. Ready can mark the valid cycles themselves, or it can lead each valid cycle by one clock so that the host can prepare to take the word.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `data_valid` low, `ready` low and `data_out` zero, and the address counter is cleared.
- R2: A cycle with `adv_n` low captures `addr_in`. The first word appears with `data_valid` high exactly LAT clock edges after the capturing edge (LAT defaults to 4). `data_valid` stays low in between.
- R3: Each word is the address zero-extended to DW bits and XORed with PATTERN (default 16'hA5C3). After the first word, each further clock delivers the word at the previous address plus one.
- R4: When the address steps from a value whose low SEG_BITS (default 6) bits are all ones to the next value, `data_valid` goes low for GAP cycles (default 2) before the next word.
- R5: The wrap from the all-ones address to address 0 is treated as a segment crossing and gets the same wait cycles.
- R6: If the captured address has low six bits 3Eh or 3Fh, the burst's first crossing inserts no wait cycles. Every later crossing does.
- R7: With `rdy_early` = 0, `ready` equals `data_valid` in every cycle.
- R8: With `rdy_early` = 1, `ready` is high exactly in the cycle before each cycle in which `data_valid` is high. It is therefore low in every wait cycle except the last one, and low while `adv_n` is low.
- R9: `adv_n` low during a burst aborts it. `data_valid` is low in the next cycle and the sequence restarts from the new address with the full latency.
- R10: Whenever `data_valid` is low, `data_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_n | input | 1 | Active-low address strobe |
| addr_in | input | AW | Starting word address |
| rdy_early | input | 1 | Ready timing: 0 same cycle as data, 1 one cycle earlier |
| data_out | output | DW | Burst data word |
| data_valid | output | 1 | data_out holds a new word this cycle |
| ready | output | 1 | Ready indication to the host |

## Verification
Some properties are checked by assertions on every cycle. These are the reset state, address continuity between back-to-back words, wait cycles that only follow a segment edge, data holding while invalid, the abort on a new strobe, and the relation between ready and valid in both timing modes. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the exact initial latency, the word values, the count of wait cycles, the waiver near a segment edge and the wrap to address 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACCESS,
      ST_BURST,
      ST_GAP
   } seq_state_t;
endpackage

// File: rtl/burst_store.sv
module burst_store #(
   parameter int          AW      = 12,
   parameter int          DW      = 16,
   parameter logic [DW-1:0] PATTERN = '0
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] word
);
   generate
      if (DW > AW) begin : g_wide
         assign word = {{(DW-AW){1'b0}}, addr} ^ PATTERN;
      end else if (DW == AW) begin : g_equal
         assign word = addr ^ PATTERN;
      end else begin : g_narrow
         assign word = addr[DW-1:0] ^ PATTERN;
      end
   endgenerate
endmodule

// File: rtl/burst_bound.sv
module burst_bound #(
   parameter int SEG_BITS = 6,
   parameter int SPAN     = 1
) (
   input  logic [SEG_BITS-1:0] low_bits,
   output logic                hit
);
   localparam logic [SEG_BITS-1:0] FIRST = SEG_BITS'((1 << SEG_BITS) - SPAN);

   if (SPAN < 1 || SPAN > (1 << SEG_BITS)) begin : g_bad_span
      $error("burst_bound: SPAN out of range");
   end

   assign hit = (low_bits >= FIRST);
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
   import burst_seq_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 16,
   parameter int LAT      = 4,
   parameter int GAP      = 2,
   parameter int SEG_BITS = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv_n,
   input  logic [AW-1:0] addr_in,
   input  logic          at_edge,
   input  logic          start_skip,
   input  logic [DW-1:0] word,
   output logic [AW-1:0] ptr,
   output logic [AW-1:0] look_addr,
   output logic [DW-1:0] data,
   output logic          valid,
   output logic          valid_nxt
);
   localparam int CMAX = (LAT > GAP) ? LAT : GAP;
   localparam int CW   = $clog2(CMAX + 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          skip;
   logic          take_gap;

   assign take_gap  = at_edge && !skip;
   assign look_addr = (state == ST_BURST) ? ptr + 1'b1 : ptr;

   always_comb begin
      valid_nxt = 1'b0;
      if (!rst && adv_n) begin
         unique case (state)
            ST_ACCESS: valid_nxt = (cnt == '0);
            ST_BURST:  valid_nxt = !take_gap;
            ST_GAP:    valid_nxt = (cnt == '0);
            default:   valid_nxt = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         ptr   <= '0;
         cnt   <= '0;
         skip  <= 1'b0;
         valid <= 1'b0;
         data  <= '0;
      end else if (!adv_n) begin
         state <= ST_ACCESS;
         ptr   <= addr_in;
         cnt   <= CW'(LAT - 1);
         skip  <= start_skip;
         valid <= 1'b0;
      end else begin
         unique case (state)
            ST_ACCESS, ST_GAP: begin
               if (cnt == '0) begin
                  valid <= 1'b1;
                  data  <= word;
                  state <= ST_BURST;
               end else begin
                  cnt   <= cnt - 1'b1;
                  valid <= 1'b0;
               end
            end
            ST_BURST: begin
               ptr <= ptr + 1'b1;
               if (at_edge) skip <= 1'b0;
               if (take_gap) begin
                  valid <= 1'b0;
                  cnt   <= CW'(GAP - 1);
                  state <= ST_GAP;
               end else begin
                  valid <= 1'b1;
                  data  <= word;
               end
            end
            default: valid <= 1'b0;
         endcase
      end
   end

   // R1: reset clears outputs and counter
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (!valid && ptr == '0 && data == '0));

   // R3: back-to-back words come from consecutive addresses
   a_r3_contiguous: assert property (@(posedge clk) disable iff (rst)
      (valid && $past(valid) && $past(adv_n)) |-> (ptr == AW'($past(ptr) + 1'b1)));

   // R4: wait cycles only occur at the start of a segment
   a_r4_gap_at_segment: assert property (@(posedge clk) disable iff (rst)
      (state == ST_GAP) |-> (ptr[SEG_BITS-1:0] == '0));

   // R9: strobe aborts the burst
   a_r9_abort: assert property (@(posedge clk) disable iff (rst)
      !adv_n |=> (!valid && state == ST_ACCESS && ptr == $past(addr_in)));

   // R10: data is held while not valid
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !valid |-> $stable(data));
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
   parameter int          AW       = 12,
   parameter int          DW       = 16,
   parameter int          LAT      = 4,
   parameter int          GAP      = 2,
   parameter int          SEG_BITS = 6,
   parameter logic [DW-1:0] PATTERN  = DW'(16'hA5C3)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv_n,
   input  logic [AW-1:0] addr_in,
   input  logic          rdy_early,
   output logic [DW-1:0] data_out,
   output logic          data_valid,
   output logic          ready
);
   if (LAT < 1)                     begin : g_bad_lat  $error("burst_seq: LAT must be >= 1"); end
   if (GAP < 1)                     begin : g_bad_gap  $error("burst_seq: GAP must be >= 1"); end
   if (SEG_BITS < 2 || SEG_BITS >= AW) begin : g_bad_seg  $error("burst_seq: SEG_BITS out of range"); end

   logic [AW-1:0] ptr;
   logic [AW-1:0] look_addr;
   logic [DW-1:0] word;
   logic          at_edge;
   logic          start_skip;
   logic          valid_nxt;

   burst_store #(.AW(AW), .DW(DW), .PATTERN(PATTERN)) store_i (
      .addr (look_addr),
      .word (word)
   );

   burst_bound #(.SEG_BITS(SEG_BITS), .SPAN(1)) edge_i (
      .low_bits (ptr[SEG_BITS-1:0]),
      .hit      (at_edge)
   );

   burst_bound #(.SEG_BITS(SEG_BITS), .SPAN(2)) near_i (
      .low_bits (addr_in[SEG_BITS-1:0]),
      .hit      (start_skip)
   );

   burst_ctrl #(
      .AW(AW), .DW(DW), .LAT(LAT), .GAP(GAP), .SEG_BITS(SEG_BITS)
   ) ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .adv_n      (adv_n),
      .addr_in    (addr_in),
      .at_edge    (at_edge),
      .start_skip (start_skip),
      .word       (word),
      .ptr        (ptr),
      .look_addr  (look_addr),
      .data       (data_out),
      .valid      (data_valid),
      .valid_nxt  (valid_nxt)
   );

   assign ready = rdy_early ? valid_nxt : data_valid;

   // R7: same-cycle ready mirrors valid
   a_r7_ready_same: assert property (@(posedge clk) disable iff (rst)
      !rdy_early |-> (ready == data_valid));

   // R8: early ready is followed by valid data
   a_r8_ready_lead: assert property (@(posedge clk) disable iff (rst)
      (rdy_early && ready && adv_n) |=> data_valid);
endmodule

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
   localparam int AW  = 12;
   localparam int DW  = 16;
   localparam int LAT = 4;
   localparam int GAP = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          adv_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          rdy_early = 1'b0;
   logic [DW-1:0] data_out;
   logic          data_valid;
   logic          ready;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string scen = "R1";

   always #5 clk = ~clk;

   burst_seq dut_i (
      .clk(clk), .rst(rst), .adv_n(adv_n), .addr_in(addr_in),
      .rdy_early(rdy_early), .data_out(data_out),
      .data_valid(data_valid), .ready(ready)
   );

   // reference model state
   bit          m_valid = 0;
   logic [DW-1:0] m_data = '0;
   bit          m_active = 0;
   int          m_stall = 0;
   int          m_nxt = 0;
   bit          m_skip = 0;

   function automatic logic [DW-1:0] word_of(int a);
      return DW'(a) ^ 16'hA5C3;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_valid = 0; m_data = '0; m_active = 0; m_stall = 0;
      end else if (!adv_n) begin
         m_nxt = int'(addr_in); m_stall = LAT;
         m_skip = ((addr_in & 12'h3F) >= 12'h3E);
         m_valid = 0; m_active = 1;
      end else if (m_active) begin
         m_stall--;
         if (m_stall == 0) begin
            m_valid = 1;
            m_data  = word_of(m_nxt);
            if ((m_nxt & 63) == 63) begin
               m_stall = m_skip ? 1 : 1 + GAP;
               m_skip  = 0;
            end else m_stall = 1;
            m_nxt = (m_nxt + 1) & ((1 << AW) - 1);
         end else m_valid = 0;
      end
   end

   task automatic chk(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", scen, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (!rst || scen == "R1") begin
         bit e_rdy;
         e_rdy = rdy_early ? (m_active && m_stall == 1 && adv_n && !rst) : m_valid;
         chk(data_valid === m_valid, "data_valid", int'(data_valid), int'(m_valid));
         chk(data_out === m_data, "data_out", int'(data_out), int'(m_data));
         chk(ready === e_rdy, "ready", int'(ready), int'(e_rdy));
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic start(logic [AW-1:0] a);
      adv_n = 1'b0; addr_in = a; step(1);
      adv_n = 1'b1; addr_in = '0;
   endtask

   initial begin
      step(3);
      rst = 1'b0;
      step(2);
      scen = "R2"; rdy_early = 1'b0; start(12'h005); step(10);
      scen = "R3"; start(12'h120); step(8);
      scen = "R4"; start(12'h03C); step(12);
      scen = "R10"; start(12'h0BD); step(10);
      scen = "R7"; start(12'h07E); step(6);
      scen = "R6"; start(12'h03E); step(75);
      start(12'h13F); step(72);
      scen = "R8"; rdy_early = 1'b1; step(1); start(12'h07A); step(15);
      start(12'h0FE); step(70);
      scen = "R5"; start(12'hFFD); step(10);
      rdy_early = 1'b0; step(1); start(12'hFFC); step(10);
      scen = "R9"; start(12'h010); step(3); start(12'h13E); step(2);
      start(12'h200); step(10);
      rdy_early = 1'b1; step(1); start(12'h03B); step(4); start(12'h07F); step(8);
      scen = "R1"; rst = 1'b1; step(2); rst = 1'b0; step(3);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule